// File: doc/BRIEF.md
# Configuration Header Clock Ratio Selector

This block watches the leading words of a configuration image as it streams past, one 32-bit word per accepted beat, and works out which clock-to-data ratio the configuration engine must use for it. Two header words matter. One carries a two-bit encryption mode field. The other carries a flag bit that is clear when the payload is compressed. The block combines these two facts with the configuration data width, which is either 16 or 32 bits, and produces a 2-bit ratio code. That code is meant to be written into the two-bit ratio field, bits [17:16], of the configuration control register at offset 0x78.

A scan begins with a one-cycle start pulse, which also samples the width select. Words are numbered from zero starting with the first word accepted after that pulse. Once the compression word has been seen, the block presents the code together with a one-cycle valid strobe. It then stops listening until the next start. If the stream is marked as ending before the compression word arrives, the block raises a one-cycle short-header error instead. The block does not decrypt or decompress anything.

Top module: `hdr_clk_ratio_sel`

## Requirements
- R1: After reset, ratio_code is 0, and ratio_valid and hdr_short_err are both low.
- R2: A start pulse begins a new scan and resets the word index. The first word with word_valid high in a later cycle is index 0. A word offered in the same cycle as start is not counted. A new start during a scan abandons that scan and forgets its encryption finding.
- R3: The image counts as encrypted when bits [3:2] of word index 69 are not both zero. No other bit of that word, and no other word, affects this.
- R4: The image counts as compressed when bit 1 of word index 229 is zero. No other bit affects this.
- R5: Ratio codes are 0 = x1, 1 = x2, 2 = x4, 3 = x8. An image that is neither encrypted nor compressed gets code 0 at both widths.
- R6: An image that is encrypted but not compressed gets code 1 at 16-bit width and code 2 at 32-bit width.
- R7: A compressed image, whether encrypted or not, gets code 2 at 16-bit width and code 3 at 32-bit width.
- R8: width_32 (1 = 32-bit, 0 = 16-bit) is sampled only in the cycle of the start pulse.
- R9: In the cycle after word 229 is accepted, ratio_valid is high for exactly one cycle and ratio_code shows the new code. ratio_code keeps that value until the next ratio_valid.
- R10: If a word carrying word_last is accepted with an index below 229, hdr_short_err is high for one cycle in the following cycle. In that case no ratio_valid is produced and ratio_code is unchanged. word_last on word 229 itself is not an error.
- R11: Words after index 229, words when no scan is open, and cycles with word_valid low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that opens a header scan |
| width_32 | input | 1 | Data width select, 1 = 32-bit, 0 = 16-bit, sampled with start |
| word_valid | input | 1 | word_data carries an image word this cycle |
| word_last | input | 1 | This word is the final word of the image |
| word_data | input | 32 | Image word |
| ratio_code | output | 2 | Clock-to-data ratio code, held between results |
| ratio_valid | output | 1 | One-cycle strobe marking a fresh ratio_code |
| hdr_short_err | output | 1 | One-cycle strobe, image ended before word 229 |

## Verification
The assertions assume that start is a single-cycle pulse and that reset is held for at least one clock edge before the first start. They also assume word_last is only meaningful together with word_valid. The stimulus raises start for exactly one cycle, always between words, except for one deliberate restart case. It drives word_last only on the final valid word of a stream, and it leaves bubbles of word_valid low inside some images so that the index is seen to advance on accepted words only. Every header word other than the two decoded ones carries a varying pattern, and the decoded words carry noise in their unused bits.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic enc;
        logic wide;
        logic [1:0] code;
        logic vld;
        logic err;
    } sel_state_t;

endpackage

// File: rtl/hdr_word_tracker.sv
module hdr_word_tracker #(
    parameter int ENC_IDX = 69,
    parameter int CMP_IDX = 229,
    parameter int IDX_W   = $clog2(CMP_IDX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic last_i,
    output logic hit_enc_o,
    output logic hit_cmp_o,
    output logic short_o,
    output logic active_o
);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t trk_d, trk_q;
    logic accept;

    always_comb begin
        accept    = trk_q.active && valid_i && !start_i;
        hit_enc_o = accept && (trk_q.idx == IDX_W'(ENC_IDX));
        hit_cmp_o = accept && (trk_q.idx == IDX_W'(CMP_IDX));
        short_o   = accept && last_i && (trk_q.idx != IDX_W'(CMP_IDX));

        trk_d = trk_q;
        if (start_i) begin
            trk_d.active = 1'b1;
            trk_d.idx    = '0;
        end else if (accept) begin
            if (hit_cmp_o || last_i) begin
                trk_d.active = 1'b0;
            end else begin
                trk_d.idx = trk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign active_o = trk_q.active;

    // R11
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.active |-> (trk_q.idx <= IDX_W'(CMP_IDX)));

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (trk_q.active && trk_q.idx == '0));

endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
    import hdr_ratio_pkg::*;
(
    input  logic       enc_i,
    input  logic       cmp_i,
    input  logic       wide_i,
    output logic [1:0] code_o
);

    ratio_e base;

    always_comb begin
        if (cmp_i) begin
            base = RATIO_X4;
        end else if (enc_i) begin
            base = RATIO_X2;
        end else begin
            base = RATIO_X1;
        end

        if (wide_i && base != RATIO_X1) begin
            code_o = 2'(base) + 2'd1;
        end else begin
            code_o = 2'(base);
        end
    end

endmodule

// File: rtl/hdr_clk_ratio_sel.sv
module hdr_clk_ratio_sel
    import hdr_ratio_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ENC_IDX = 69,
    parameter int CMP_IDX = 229,
    parameter int ENC_LSB = 2,
    parameter int CMP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              width_32,
    input  logic              word_valid,
    input  logic              word_last,
    input  logic [DATA_W-1:0] word_data,
    output logic [1:0]        ratio_code,
    output logic              ratio_valid,
    output logic              hdr_short_err
);

    localparam int IDX_W = $clog2(CMP_IDX + 1);

    sel_state_t st_d, st_q;
    logic hit_enc, hit_cmp, short_hit, trk_active;
    logic [1:0] mapped_code;
    logic unused_bits;

    assign unused_bits = ^word_data;

    hdr_word_tracker #(
        .ENC_IDX (ENC_IDX),
        .CMP_IDX (CMP_IDX),
        .IDX_W   (IDX_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .valid_i   (word_valid),
        .last_i    (word_last),
        .hit_enc_o (hit_enc),
        .hit_cmp_o (hit_cmp),
        .short_o   (short_hit),
        .active_o  (trk_active)
    );

    hdr_ratio_map u_map (
        .enc_i  (st_q.enc),
        .cmp_i  (!word_data[CMP_BIT]),
        .wide_i (st_q.wide),
        .code_o (mapped_code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (start) begin
            st_d.enc  = 1'b0;
            st_d.wide = width_32;
        end
        if (hit_enc) begin
            st_d.enc = |word_data[ENC_LSB+1:ENC_LSB];
        end
        if (hit_cmp) begin
            st_d.code = mapped_code;
            st_d.vld  = 1'b1;
        end
        if (short_hit) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_code    = st_q.code;
    assign ratio_valid   = st_q.vld;
    assign hdr_short_err = st_q.err;

    // R9
    ratio_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_valid |=> !ratio_valid);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_valid |-> $stable(ratio_code));

    // R10
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_short_err |-> !ratio_valid);

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_short_err |-> $past(trk_active));

endmodule

// File: tb/hdr_clk_ratio_sel_tb.sv
module hdr_clk_ratio_sel_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic width_32 = 1'b0;
    logic word_valid = 1'b0;
    logic word_last = 1'b0;
    logic [31:0] word_data = '0;
    logic [1:0] ratio_code;
    logic ratio_valid;
    logic hdr_short_err;

    int n_tests = 0;
    int n_fail = 0;
    logic [1:0] held_code = 2'd0;

    always #2 clk = ~clk;

    hdr_clk_ratio_sel u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .width_32      (width_32),
        .word_valid    (word_valid),
        .word_last     (word_last),
        .word_data     (word_data),
        .ratio_code    (ratio_code),
        .ratio_valid   (ratio_valid),
        .hdr_short_err (hdr_short_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] make_word(input int i, input logic [1:0] encf, input logic b1);
        logic [31:0] w;
        w = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A00F0;
        if (i == 69)  w = (w & ~32'hC) | {28'd0, encf, 2'b00};
        if (i == 229) w = (w & ~32'h2) | {30'd0, b1, 1'b0};
        return w;
    endfunction

    function automatic logic [1:0] expect_code(input logic [1:0] encf, input logic b1, input logic w32);
        int base;
        base = (!b1) ? 2 : ((encf != 2'b00) ? 1 : 0);
        if (w32 && base != 0) base = base + 1;
        return 2'(base);
    endfunction

    task automatic pulse_start(input logic w32);
        @(negedge clk);
        start = 1'b1; width_32 = w32; word_valid = 1'b0; word_last = 1'b0;
        @(negedge clk);
        start = 1'b0; width_32 = ~w32;
    endtask

    task automatic send_words(input int n, input logic [1:0] encf, input logic b1,
                              input bit mark_last, input bit gap);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 5) == 2) begin
                @(negedge clk);
                word_valid = 1'b0; word_data = 32'hFFFF_FFFF;
            end
            @(negedge clk);
            // R11 nothing emitted before the compression word is accepted
            check("R11 early strobe", {30'd0, ratio_valid, hdr_short_err}, 32'd0);
            word_valid = 1'b1;
            word_data  = make_word(i, encf, b1);
            word_last  = mark_last && (i == n - 1);
        end
        @(negedge clk);
        word_valid = 1'b0; word_last = 1'b0;
    endtask

    task automatic run_image(input logic [1:0] encf, input logic b1, input logic w32, input bit gap);
        logic [1:0] exp;
        exp = expect_code(encf, b1, w32);
        pulse_start(w32);
        send_words(230, encf, b1, 1'b0, gap);
        // R5 R6 R7 R3 R4 R8 code follows the mapping
        check("R9 ratio_valid pulse", {31'd0, ratio_valid}, 32'd1);
        check("R5/R6/R7 code", {30'd0, ratio_code}, {30'd0, exp});
        check("R10 no error on full header", {31'd0, hdr_short_err}, 32'd0);
        @(negedge clk);
        check("R9 single-cycle strobe", {31'd0, ratio_valid}, 32'd0);
        check("R9 code held", {30'd0, ratio_code}, {30'd0, exp});
        held_code = exp;
    endtask

    task automatic run_short(input int n);
        pulse_start(1'b1);
        send_words(n, 2'b11, 1'b0, 1'b1, 1'b0);
        // R10 short header flagged
        check("R10 short error", {31'd0, hdr_short_err}, 32'd1);
        check("R10 no ratio_valid", {31'd0, ratio_valid}, 32'd0);
        check("R10 code unchanged", {30'd0, ratio_code}, {30'd0, held_code});
        @(negedge clk);
        check("R10 error one cycle", {31'd0, hdr_short_err}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset code", {30'd0, ratio_code}, 32'd0);
        check("R1 reset strobes", {30'd0, ratio_valid, hdr_short_err}, 32'd0);
        rst_n = 1'b1;

        // R11 words with no open scan are ignored
        send_words(240, 2'b01, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R11 unstarted ignored", {29'd0, ratio_code, ratio_valid}, 32'd0);

        // R3 R4 R5 R6 R7 R8 full sweep: encryption field, compression bit, width
        for (int e = 0; e < 4; e++) begin
            for (int b = 0; b < 2; b++) begin
                for (int w = 0; w < 2; w++) begin
                    run_image(2'(e), 1'(b), 1'(w), ((e + b + w) % 2) == 1);
                end
            end
        end

        // R10 short headers of several lengths
        run_short(1);
        run_short(70);
        run_short(229);

        // R10 last on word 229 is not an error
        pulse_start(1'b0);
        send_words(230, 2'b10, 1'b1, 1'b1, 1'b0);
        check("R10 last on final word ok", {30'd0, ratio_valid, hdr_short_err}, 32'd2);
        check("R6 code", {30'd0, ratio_code}, 32'd1);
        held_code = 2'd1;

        // R11 tail words after the header change nothing
        send_words(6, 2'b00, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R11 tail ignored", {29'd0, ratio_code, ratio_valid}, {29'd0, held_code, 1'b0});
        check("R11 tail no error", {31'd0, hdr_short_err}, 32'd0);

        // R2 restart mid-scan forgets the encryption finding
        pulse_start(1'b1);
        send_words(100, 2'b11, 1'b1, 1'b0, 1'b0);
        run_image(2'b00, 1'b1, 1'b1, 1'b0);
        check("R2 restart clears enc", {30'd0, ratio_code}, 32'd0);

        // R2 word offered together with start is not counted
        @(negedge clk);
        start = 1'b1; width_32 = 1'b0;
        word_valid = 1'b1; word_data = 32'h0000_000C;
        @(negedge clk);
        start = 1'b0;
        word_valid = 1'b0;
        send_words(230, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R2 start-cycle word dropped", {29'd0, ratio_code, ratio_valid}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule